// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Datapath

This block is a small in-order processor datapath split into five stages: instruction fetch, register read, ALU, data memory and register write, with a pipeline register between each pair of stages. It executes a four-operation instruction set: register add, branch to a register-held target when a register is zero, load word with base plus signed offset, and store word with base plus signed offset. Instruction and data storage are internal arrays. A load port fills them while the core is held in reset.

Fetch always runs ahead on the sequential path. A branch is resolved in the ALU stage. When it is taken, the two younger instructions already in flight are cancelled. A consumer that depends on a result not yet written back waits in the register-read stage until the write happens. The register file passes a same-cycle write straight through to a read.

A build parameter selects one shared array for code and data instead of two arrays. In that build, a load or store in the memory stage takes the array for that cycle, so fetch inserts a bubble. A retired-instruction counter and a register debug read port let a bench compare architectural results and timing.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted and right after it, the retired count is 0 and every register reads 0 on the debug port.
- R2: Instructions are 32-bit words. Bits [31:30] are the opcode (00 add, 01 branch-if-zero, 10 load, 11 store). Bits [29:25] are source A, [24:20] source B, [19:15] destination, and [14:0] a two's-complement offset. The PC is a byte address that starts at 0 and advances by 4. Both memories are indexed by address bits [AW+1:2].
- R3: Add writes A+B into the destination register.
- R4: Register 0 always reads as 0, and writes to it are discarded.
- R5: Load writes memory[A+offset] into the destination register. Store writes B to memory[A+offset]. Negative offsets work.
- R6: Store never writes a register, whatever its destination field holds.
- R7: Branch-if-zero with A equal to 0 sends fetch to the address held in B. The two younger instructions are cancelled and never change state, which costs 2 cycles.
- R8: Branch-if-zero with A not equal to 0 falls through with no lost cycle.
- R9: A source that matches the destination of an older, unretired writer stalls register read. An adjacent producer costs 2 bubbles, a producer two ahead costs 1, and a producer three ahead costs none because of the write-to-read bypass.
- R10: The retired count rises by one for each instruction that completes the last stage, including stores and branches. Bubbles are not counted.
- R11: In the shared-memory build, each load or store in the memory stage blocks that cycle's fetch and costs one bubble, and results stay the same as in the split build.
- R12: The load port writes word ld_addr of instruction memory (ld_dmem=0) or data memory (ld_dmem=1) on a clock edge. The debug port returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Memory load strobe |
| ld_dmem | input | 1 | Load target: 0 instruction array, 1 data array |
| ld_addr | input | AW | Word index for the load |
| ld_data | input | 32 | Word to load |
| dbg_raddr | input | 5 | Register debug read index |
| dbg_rdata | output | 32 | Register debug read data |
| retired_cnt | output | CNT_W | Count of completed instructions |

## Verification
The bench measures the clock edge at which the retired count reaches a target, which exposes each interlock's cost in cycles. A missing RAW stall would let an adder read a stale zero. A stall that lasts too long, or a broken bypass, would shift that edge later. A taken branch that fails to squash would leave a register written on the wrong path. Squashing on a not-taken branch would lose a write and delay retirement. Further tests cover a store with a non-zero destination field, a negative load offset, and a write to register 0. The shared-memory build runs the same programs, where a missing structural stall would show up as an early retirement edge.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int NREGS  = 1 << RIDX_W;
    localparam int IMM_W  = 15;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_BEZ = 2'd1,
        OP_LD  = 2'd2,
        OP_ST  = 2'd3
    } op_e;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] ins;
    } ifid_t;

    typedef struct packed {
        logic              vld;
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [XLEN-1:0]   imm;
    } idex_t;

    typedef struct packed {
        logic              vld;
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   res;
        logic [XLEN-1:0]   sdata;
    } exmem_t;

    typedef struct packed {
        logic              vld;
        logic              wen;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   wdata;
    } memwb_t;

    function automatic logic writes_rd(op_e op);
        return (op == OP_ADD) || (op == OP_LD);
    endfunction

    function automatic logic reads_b(op_e op);
        return op != OP_LD;
    endfunction

    function automatic logic touches_mem(op_e op);
        return (op == OP_LD) || (op == OP_ST);
    endfunction
endpackage

// File: rtl/p5_regfile.sv
module p5_regfile import pipe5_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] ra1,
    output logic [XLEN-1:0]   rd1,
    input  logic [RIDX_W-1:0] ra2,
    output logic [XLEN-1:0]   rd2,
    input  logic [RIDX_W-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data
);
    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];
    logic            wr_ok;

    assign wr_ok = we && (waddr != '0);

    always_comb begin
        regs_d = regs_q;
        if (wr_ok) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{default: '0};
        else        regs_q <= regs_d;
    end

    // same-cycle write passes through to the reads
    assign rd1      = (wr_ok && waddr == ra1) ? wdata : regs_q[ra1];
    assign rd2      = (wr_ok && waddr == ra2) ? wdata : regs_q[ra2];
    assign dbg_data = regs_q[dbg_addr];
endmodule

// File: rtl/p5_memory.sv
module p5_memory import pipe5_pkg::*; #(
    parameter int WORDS  = 64,
    parameter int SHARED = 0,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            ld_en,
    input  logic            ld_dmem,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [AW-1:0]   if_addr,
    output logic [XLEN-1:0] if_data,
    input  logic            d_we,
    input  logic [AW-1:0]   d_addr,
    input  logic [XLEN-1:0] d_wdata,
    output logic [XLEN-1:0] d_rdata
);
    generate
        if (SHARED != 0) begin : g_shared
            logic [XLEN-1:0] arr [WORDS];
            logic            sel_unused;
            assign sel_unused = ld_dmem;
            always_ff @(posedge clk) begin
                if (ld_en)     arr[ld_addr] <= ld_data;
                else if (d_we) arr[d_addr]  <= d_wdata;
            end
            assign if_data = arr[if_addr];
            assign d_rdata = arr[d_addr];
        end else begin : g_split
            logic [XLEN-1:0] iarr [WORDS];
            logic [XLEN-1:0] darr [WORDS];
            always_ff @(posedge clk) begin
                if (ld_en && !ld_dmem) iarr[ld_addr] <= ld_data;
            end
            always_ff @(posedge clk) begin
                if (ld_en && ld_dmem) darr[ld_addr] <= ld_data;
                else if (d_we)        darr[d_addr]  <= d_wdata;
            end
            assign if_data = iarr[if_addr];
            assign d_rdata = darr[d_addr];
        end
    endgenerate
endmodule

// File: rtl/p5_hazard.sv
module p5_hazard import pipe5_pkg::*; #(
    parameter int SHARED = 0
) (
    input  logic              id_vld,
    input  op_e               id_op,
    input  logic [RIDX_W-1:0] id_ra,
    input  logic [RIDX_W-1:0] id_rb,
    input  logic              ex_vld,
    input  op_e               ex_op,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic              mem_vld,
    input  op_e               mem_op,
    input  logic [RIDX_W-1:0] mem_rd,
    output logic              raw_stall,
    output logic              fetch_block
);
    logic ex_w, mem_w, dep_a, dep_b;

    assign ex_w  = ex_vld && writes_rd(ex_op) && (ex_rd != '0);
    assign mem_w = mem_vld && writes_rd(mem_op) && (mem_rd != '0);
    assign dep_a = (id_ra != '0) &&
                   ((ex_w && ex_rd == id_ra) || (mem_w && mem_rd == id_ra));
    assign dep_b = reads_b(id_op) && (id_rb != '0) &&
                   ((ex_w && ex_rd == id_rb) || (mem_w && mem_rd == id_rb));
    assign raw_stall = id_vld && (dep_a || dep_b);

    generate
        if (SHARED != 0) begin : g_port_conflict
            assign fetch_block = mem_vld && touches_mem(mem_op);
        end else begin : g_no_conflict
            assign fetch_block = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core import pipe5_pkg::*; #(
    parameter int MEM_WORDS  = 64,
    parameter int SHARED_MEM = 0,
    parameter int CNT_W      = 16,
    localparam int AW        = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [AW-1:0]     ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    input  logic [RIDX_W-1:0] dbg_raddr,
    output logic [XLEN-1:0]   dbg_rdata,
    output logic [CNT_W-1:0]  retired_cnt
);
    typedef struct packed {
        logic [XLEN-1:0]  pc;
        ifid_t            ifid;
        idex_t            idex;
        exmem_t           exmem;
        memwb_t           memwb;
        logic [CNT_W-1:0] retired;
    } state_t;

    state_t s_d, s_q;

    op_e               id_op;
    logic [RIDX_W-1:0] id_ra, id_rb, id_rd;
    logic [XLEN-1:0]   id_imm, rf_a, rf_b;
    logic [XLEN-1:0]   if_data, d_rdata, ex_res;
    logic              raw_stall, fetch_block, br_taken, d_we;

    assign id_op  = op_e'(s_q.ifid.ins[31:30]);
    assign id_ra  = s_q.ifid.ins[29:25];
    assign id_rb  = s_q.ifid.ins[24:20];
    assign id_rd  = s_q.ifid.ins[19:15];
    assign id_imm = {{(XLEN-IMM_W){s_q.ifid.ins[IMM_W-1]}}, s_q.ifid.ins[IMM_W-1:0]};
    assign d_we   = s_q.exmem.vld && (s_q.exmem.op == OP_ST);

    p5_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(s_q.memwb.wen), .waddr(s_q.memwb.rd), .wdata(s_q.memwb.wdata),
        .ra1(id_ra), .rd1(rf_a), .ra2(id_rb), .rd2(rf_b),
        .dbg_addr(dbg_raddr), .dbg_data(dbg_rdata)
    );

    p5_memory #(.WORDS(MEM_WORDS), .SHARED(SHARED_MEM)) u_mem (
        .clk(clk), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr), .ld_data(ld_data),
        .if_addr(s_q.pc[AW+1:2]), .if_data(if_data),
        .d_we(d_we), .d_addr(s_q.exmem.res[AW+1:2]), .d_wdata(s_q.exmem.sdata),
        .d_rdata(d_rdata)
    );

    p5_hazard #(.SHARED(SHARED_MEM)) u_hz (
        .id_vld(s_q.ifid.vld), .id_op(id_op), .id_ra(id_ra), .id_rb(id_rb),
        .ex_vld(s_q.idex.vld), .ex_op(s_q.idex.op), .ex_rd(s_q.idex.rd),
        .mem_vld(s_q.exmem.vld), .mem_op(s_q.exmem.op), .mem_rd(s_q.exmem.rd),
        .raw_stall(raw_stall), .fetch_block(fetch_block)
    );

    assign br_taken = s_q.idex.vld && (s_q.idex.op == OP_BEZ) && (s_q.idex.a == '0);
    assign ex_res   = (s_q.idex.op == OP_ADD) ? (s_q.idex.a + s_q.idex.b)
                                              : (s_q.idex.a + s_q.idex.imm);

    always_comb begin
        s_d = s_q;

        // register write stage: count completions
        s_d.retired = s_q.retired + CNT_W'(s_q.memwb.vld);

        // memory stage -> write-back register
        s_d.memwb.vld   = s_q.exmem.vld;
        s_d.memwb.wen   = s_q.exmem.vld && writes_rd(s_q.exmem.op) && (s_q.exmem.rd != '0);
        s_d.memwb.rd    = s_q.exmem.rd;
        s_d.memwb.wdata = (s_q.exmem.op == OP_LD) ? d_rdata : s_q.exmem.res;

        // ALU stage -> memory register
        s_d.exmem.vld   = s_q.idex.vld;
        s_d.exmem.op    = s_q.idex.op;
        s_d.exmem.rd    = s_q.idex.rd;
        s_d.exmem.res   = ex_res;
        s_d.exmem.sdata = s_q.idex.b;

        // register read stage -> ALU register
        s_d.idex.vld = s_q.ifid.vld && !raw_stall && !br_taken;
        s_d.idex.op  = id_op;
        s_d.idex.rd  = id_rd;
        s_d.idex.a   = rf_a;
        s_d.idex.b   = rf_b;
        s_d.idex.imm = id_imm;

        // fetch and PC
        if (br_taken) begin
            s_d.ifid.vld = 1'b0;
            s_d.pc       = s_q.idex.b;
        end else if (raw_stall) begin
            s_d.ifid = s_q.ifid;
            s_d.pc   = s_q.pc;
        end else if (fetch_block) begin
            s_d.ifid.vld = 1'b0;
            s_d.pc       = s_q.pc;
        end else begin
            s_d.ifid.vld = 1'b1;
            s_d.ifid.ins = if_data;
            s_d.pc       = s_q.pc + XLEN'(4);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign retired_cnt = s_q.retired;
endmodule

// File: rtl/p5_checker.sv
module p5_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       dbg_raddr,
    input logic [31:0]      dbg_rdata,
    input logic [CNT_W-1:0] retired,
    input logic             br_taken,
    input logic             raw_stall,
    input logic             fetch_block,
    input logic [31:0]      pc,
    input logic             ifid_vld,
    input logic             idex_vld,
    input logic             st_in_mem,
    input logic             rf_we
);
    a_r4_zero_reg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_raddr == 5'd0) |-> (dbg_rdata == 32'd0));

    a_r10_retire_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((retired == $past(retired)) || (retired == $past(retired) + 1'b1)));

    a_r7_taken_squashes_young: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (!ifid_vld && !idex_vld));

    a_r9_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stall && !br_taken) |=> $stable(pc));

    a_r11_conflict_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_block && !raw_stall && !br_taken) |=> !ifid_vld);

    a_r6_store_no_reg_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_in_mem |=> !rf_we);
endmodule

bind pipe5_core p5_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata),
    .retired(retired_cnt),
    .br_taken(br_taken), .raw_stall(raw_stall), .fetch_block(fetch_block),
    .pc(s_q.pc), .ifid_vld(s_q.ifid.vld), .idex_vld(s_q.idex.vld),
    .st_in_mem(d_we), .rf_we(s_q.memwb.wen)
);

// File: tb/sim_pipe5_core.sv
module sim_pipe5_core;
    localparam int WORDS = 64;
    localparam int AW    = 6;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic          ld_dmem = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [4:0]    dbg_raddr = '0;
    logic [31:0]   dbg0, dbg1;
    logic [CW-1:0] ret0, ret1;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pipe5_core #(.MEM_WORDS(WORDS), .SHARED_MEM(0), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_raddr(dbg_raddr),
        .dbg_rdata(dbg0), .retired_cnt(ret0));

    pipe5_core #(.MEM_WORDS(WORDS), .SHARED_MEM(1), .CNT_W(CW)) u1 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_raddr(dbg_raddr),
        .dbg_rdata(dbg1), .retired_cnt(ret1));

    // opcodes per R2
    localparam logic [1:0] ADD = 2'd0, BEZ = 2'd1, LD = 2'd2, ST = 2'd3;

    function automatic logic [31:0] enc(logic [1:0] op, int a, int b, int d, int imm);
        logic [31:0] w;
        w = {op, a[4:0], b[4:0], d[4:0], imm[14:0]};
        return w;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(logic dm, int idx, logic [31:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_dmem = dm; ld_addr = idx[AW-1:0]; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // R12: load port used to wipe both arrays while held in reset
    task automatic prep();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            put(1'b0, i, 32'd0);
            put(1'b1, i, 32'd0);
        end
    endtask

    task automatic run_prog(int n, int edges, output int k0, output int k1);
        k0 = -1; k1 = -1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= edges; k++) begin
            @(posedge clk);
            #1;
            if (k0 < 0 && int'(ret0) >= n) k0 = k;
            if (k1 < 0 && int'(ret1) >= n) k1 = k;
        end
    endtask

    task automatic rd_reg(int r, output longint v0, output longint v1);
        dbg_raddr = r[4:0];
        #1;
        v0 = dbg0; v1 = dbg1;
    endtask

    task automatic t_add_ld_st();
        int k0, k1; longint v0, v1;
        prep();
        put(1'b1, 32, 32'd140);
        put(1'b1, 33, 32'd77);
        put(1'b0, 0, enc(LD, 0, 0, 1, 128));
        put(1'b0, 1, enc(LD, 0, 0, 2, 132));
        put(1'b0, 2, enc(ST, 1, 2, 9, -4));    // mem[34] = 77, dest field 9
        put(1'b0, 3, enc(LD, 0, 0, 3, 136));
        put(1'b0, 4, enc(ADD, 2, 2, 0, 0));    // write to r0
        put(1'b0, 5, enc(ADD, 0, 2, 4, 0));
        put(1'b0, 6, enc(ADD, 1, 2, 5, 0));
        put(1'b0, 7, enc(LD, 1, 0, 6, -8));    // mem[33]
        run_prog(1, 60, k0, k1);
        rd_reg(3, v0, v1);
        chk("R5", "store then load r3 split", v0, 77);
        chk("R11", "store then load r3 shared", v1, 77);
        rd_reg(9, v0, v1);
        chk("R6", "store dest field r9", v0, 0);
        rd_reg(0, v0, v1);
        chk("R4", "r0 after write", v0, 0);
        rd_reg(4, v0, v1);
        chk("R4", "r0 as source", v0, 77);
        rd_reg(5, v0, v1);
        chk("R3", "add r5", v0, 217);
        chk("R11", "add r5 shared", v1, 217);
        rd_reg(6, v0, v1);
        chk("R5", "negative offset load", v0, 77);
    endtask

    task automatic t_reset();
        longint v0, v1;
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "retired in reset", ret0, 0);
        for (int r = 1; r < 7; r++) begin
            rd_reg(r, v0, v1);
            chk("R1", "register cleared", v0, 0);
        end
    endtask

    task automatic t_raw();
        int k0, k1; longint v0, v1;
        prep();
        put(1'b1, 32, 32'd21);
        put(1'b0, 0, enc(LD, 0, 0, 1, 128));
        put(1'b0, 1, enc(ADD, 1, 1, 2, 0));    // adjacent: 2 bubbles
        put(1'b0, 2, enc(ADD, 0, 0, 3, 0));
        put(1'b0, 3, enc(ADD, 2, 0, 4, 0));    // two ahead: 1 bubble
        run_prog(4, 40, k0, k1);
        chk("R9", "edge of 4th retire", k0, 11);
        chk("R10", "bubbles not counted", k0 - 4, 7);
        rd_reg(2, v0, v1);
        chk("R9", "dependent add r2", v0, 42);
        rd_reg(4, v0, v1);
        chk("R9", "second dependent r4", v0, 42);
    endtask

    task automatic t_branch(bit taken);
        int k0, k1; longint v0, v1;
        prep();
        put(1'b1, 35, 32'd20);
        put(1'b0, 0, enc(LD, 0, 0, 5, 140));
        put(1'b0, 3, enc(BEZ, taken ? 0 : 5, 5, 0, 0)); // three ahead: bypass
        put(1'b0, 4, enc(ADD, 5, 5, 6, 0));
        put(1'b0, 5, enc(ADD, 5, 5, 7, 0));
        run_prog(5, 40, k0, k1);
        rd_reg(6, v0, v1);
        rd_reg(7, v0, v1);
        if (taken) begin
            chk("R7", "edge of 5th retire", k0, 11);
            rd_reg(6, v0, v1);
            chk("R7", "wrong path r6", v0, 0);
            rd_reg(7, v0, v1);
            chk("R7", "target r7", v0, 40);
        end else begin
            chk("R8", "edge of 5th retire", k0, 9);
            rd_reg(6, v0, v1);
            chk("R8", "fall through r6", v0, 40);
            chk("R8", "fall through r6 shared", v1, 40);
        end
    endtask

    task automatic t_shared();
        int k0, k1; longint v0, v1;
        prep();
        put(1'b1, 32, 32'd9);
        put(1'b0, 0, enc(LD, 0, 0, 1, 128));
        put(1'b0, 1, enc(ADD, 0, 0, 2, 0));
        put(1'b0, 3, enc(ADD, 1, 1, 3, 0));
        run_prog(4, 40, k0, k1);
        chk("R11", "split 4th retire edge", k0, 8);
        chk("R11", "shared 4th retire edge", k1, 9);
        rd_reg(3, v0, v1);
        chk("R11", "shared result r3", v1, 18);
        chk("R3", "split result r3", v0, 18);
    endtask

    initial begin
        t_add_ld_st();
        t_reset();
        t_raw();
        t_branch(1'b1);
        t_branch(1'b0);
        t_shared();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule